// File: doc/BRIEF.md
# Interrupt Status and Holdoff Controller

This block gathers single-cycle event pulses from the subsystems of a network adapter and keeps each one as a sticky bit in a status register. Software can read that register through two views. The peek view only reports the pending bits. The acknowledge view reports them and clears exactly the bits it returned. A mask register selects which pending bits may drive the interrupt line.

A control register does three things. It holds the engine enables, a transmit lock/stream mode bit and a 3-bit interrupt select value. It can also start a short or a long holdoff window. During that window events keep latching, but the interrupt line is forced low.

The holdoff timer is a state machine with three states. `HO_IDLE` means no window is running. `HO_SHORT` means a short window is running for `SHORT_CYC` cycles. `HO_LONG` means a long window is running for `LONG_CYC` cycles. It has these transitions:
- IDLE to SHORT on a short request.
- IDLE to LONG, or SHORT to LONG, on a long request.
- Any state to SHORT on a short request alone, which restarts the window.
- SHORT or LONG back to IDLE when the counter reaches zero.
- Any state to IDLE on a soft reset.

Top module: `irq_holdoff_ctrl`

## Requirements
- R1: After reset, the irq output is 0. Reads of the peek, acknowledge, mask and control registers return 0, and every control output is 0.
- R2: A pulse on `evt_pulse[i]` sets status bit i at the next clock edge. The bit stays set until the acknowledge view clears it. The bit layout is:
  - bit 0: statistics
  - bit 1: physical layer
  - bit 2: service list
  - bit 3: transmit DMA done
  - bit 4: receive DMA done
  - bit 5: DMA error
  - bit 6: DMA length error
  - bit 7: descriptor identifier mismatch
  - bit 8: DMA overflow
  - bits 16:9: transmit channels 0 to 7
- R3: A read of offset 1 (peek) returns the status, zero-extended, in the same cycle and clears nothing.
- R4: A read of offset 2 (acknowledge) returns the status and clears exactly the returned bits at that clock edge. An event arriving in that same cycle keeps its bit set.
- R5: The mask register at offset 3 is written and read at bits 16:0, with the same layout as the status. `irq` is the registered OR of (status AND mask), one cycle behind the status, whenever no holdoff is active.
- R6: A control write (offset 4) with bit 0 set holds `irq` low for `SHORT_CYC` cycles. A control write with bit 1 set holds it low for `LONG_CYC` cycles, and bit 1 wins if both are set. Control read bits 0 and 1 show the short and long windows while they run and clear by themselves. Events still latch during a window.
- R7: Control bits 8:2 are stored and read back. They drive these outputs:
  - bit 2: `rx_on`
  - bit 3: `tx_on`
  - bit 4: `dma_on`
  - bit 5: `tx_lock` (1 = lock mode)
  - bits 8:6: `irq_sel`
- R8: A read of offset 0 returns `CHIP_VER` in bits 31:27 and `BOARD_ID` in bits 11:0. A write to offset 0 clears status, mask, control and holdoff, and pulses `sw_rst` for one cycle.
- R9: Reads of offsets 5 to 7 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| evt_pulse | input | 17 | Event pulses, one per status bit |
| irq | output | 1 | Interrupt request |
| sw_rst | output | 1 | One-cycle pulse after a write to offset 0 |
| rx_on | output | 1 | Receive engine enable |
| tx_on | output | 1 | Transmit engine enable |
| dma_on | output | 1 | DMA enable |
| tx_lock | output | 1 | Transmit lock mode (0 = streaming) |
| irq_sel | output | 3 | Interrupt select value |

## Verification
On every cycle, the assertions check three things:
- Events land in status, and a peek never drops a bit.
- An acknowledge clears only unrenewed returned bits.
- A running holdoff counter stays in range and ends in idle, and an unmasked pending bit raises irq outside holdoff.

The bench scenarios show the rest:
- The exact holdoff lengths and the priority of the long window.
- The identifier value and the soft-reset pulse.
- The readback of the control fields.
- The silence of unused offsets.
- The cycle-exact agreement of a random mix of events, reads and mask writes with a reference model.

// File: rtl/ihc_pkg.sv
package ihc_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int EVT_W  = 17;
    localparam int CTRL_W = 9;

    localparam logic [ADDR_W-1:0] OFF_ID   = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_PEEK = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_ACK  = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_MASK = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd4;

    typedef enum logic [1:0] {
        HO_IDLE  = 2'd0,
        HO_SHORT = 2'd1,
        HO_LONG  = 2'd2
    } ho_state_e;
endpackage

// File: rtl/ihc_status_bank.sv
module ihc_status_bank #(
    parameter int W = ihc_pkg::EVT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] evt,
    input  logic         ack_rd,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         pend
);
    logic [W-1:0] clear_bits;

    always_comb clear_bits = ack_rd ? status : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '0;
            pend   <= 1'b0;
        end else if (clr) begin
            status <= '0;
            mask   <= '0;
            pend   <= 1'b0;
        end else begin
            status <= (status & ~clear_bits) | evt;
            if (mask_we) mask <= mask_wdata;
            pend   <= |(status & mask);
        end
    end

    assert_event_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (|evt)) |=> ((status & $past(evt)) == $past(evt)));

    assert_peek_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ack_rd) |=> (($past(status) & ~status) == '0));

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ack_rd) |=> ((status & $past(status & ~evt)) == '0));
endmodule

// File: rtl/ihc_holdoff_fsm.sv
module ihc_holdoff_fsm #(
    parameter int SHORT_CYC = 25000,
    parameter int LONG_CYC  = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic req_short,
    input  logic req_long,
    output logic active,
    output logic short_act,
    output logic long_act
);
    import ihc_pkg::*;

    localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 1);
    localparam logic [CNT_W-1:0] MAX_LD   = CNT_W'(MAX_CYC - 1);

    ho_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HO_IDLE: begin
                cnt_d = '0;
            end
            HO_SHORT, HO_LONG: begin
                if (cnt_q == '0) state_d = HO_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = HO_IDLE;
        endcase
        if (req_long) begin
            state_d = HO_LONG;
            cnt_d   = LONG_LD;
        end else if (req_short) begin
            state_d = HO_SHORT;
            cnt_d   = SHORT_LD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HO_IDLE;
            cnt_q   <= '0;
        end else if (clr) begin
            state_q <= HO_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        active    = 1'b0;
        short_act = 1'b0;
        long_act  = 1'b0;
        unique case (state_q)
            HO_IDLE:  ;
            HO_SHORT: begin active = 1'b1; short_act = 1'b1; end
            HO_LONG:  begin active = 1'b1; long_act  = 1'b1; end
            default:  ;
        endcase
    end

    assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != HO_IDLE) |-> (cnt_q <= MAX_LD));

    assert_window_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != HO_IDLE && cnt_q == '0 && !req_short && !req_long) |=> (state_q == HO_IDLE));
endmodule

// File: rtl/irq_holdoff_ctrl.sv
module irq_holdoff_ctrl #(
    parameter int          SHORT_CYC = 25000,
    parameter int          LONG_CYC  = 50000,
    parameter logic [4:0]  CHIP_VER  = 5'h03,
    parameter logic [11:0] BOARD_ID  = 12'h1A7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [16:0] evt_pulse,
    output logic        irq,
    output logic        sw_rst,
    output logic        rx_on,
    output logic        tx_on,
    output logic        dma_on,
    output logic        tx_lock,
    output logic [2:0]  irq_sel
);
    import ihc_pkg::*;

    localparam int FLD_W = CTRL_W - 2;

    logic              wr_id, wr_ctrl, wr_mask, rd_ack;
    logic [EVT_W-1:0]  status, mask;
    logic              pend, ho_active, ho_short, ho_long;
    logic [FLD_W-1:0]  ctrl_q;
    logic              sw_rst_q;

    always_comb begin
        wr_id   = bus_wr && (bus_addr == OFF_ID);
        wr_ctrl = bus_wr && (bus_addr == OFF_CTRL);
        wr_mask = bus_wr && (bus_addr == OFF_MASK);
        rd_ack  = bus_rd && (bus_addr == OFF_ACK);
    end

    ihc_status_bank #(.W(EVT_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (wr_id),
        .evt        (evt_pulse),
        .ack_rd     (rd_ack),
        .mask_we    (wr_mask),
        .mask_wdata (bus_wdata[EVT_W-1:0]),
        .status     (status),
        .mask       (mask),
        .pend       (pend)
    );

    ihc_holdoff_fsm #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (wr_id),
        .req_short (wr_ctrl && bus_wdata[0]),
        .req_long  (wr_ctrl && bus_wdata[1]),
        .active    (ho_active),
        .short_act (ho_short),
        .long_act  (ho_long)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            sw_rst_q <= 1'b0;
        end else begin
            sw_rst_q <= wr_id;
            if (wr_id)        ctrl_q <= '0;
            else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:2];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFF_ID:            bus_rdata = {CHIP_VER, 15'd0, BOARD_ID};
                OFF_PEEK, OFF_ACK: bus_rdata = {{(DATA_W-EVT_W){1'b0}}, status};
                OFF_MASK:          bus_rdata = {{(DATA_W-EVT_W){1'b0}}, mask};
                OFF_CTRL:          bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q, ho_long, ho_short};
                default:           bus_rdata = '0;
            endcase
        end
    end

    always_comb begin
        irq     = pend && !ho_active;
        sw_rst  = sw_rst_q;
        rx_on   = ctrl_q[0];
        tx_on   = ctrl_q[1];
        dma_on  = ctrl_q[2];
        tx_lock = ctrl_q[3];
        irq_sel = ctrl_q[6:4];
    end

    assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(status & mask)) && !wr_id) |=> (irq || ho_active));

    assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_id |=> (sw_rst && !irq && status == '0));
endmodule

// File: tb/irq_holdoff_ctrl_bench.sv
module irq_holdoff_ctrl_bench;
    localparam int SC = 20;
    localparam int LC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [16:0] evt_pulse = '0;
    logic        irq, sw_rst, rx_on, tx_on, dma_on, tx_lock;
    logic [2:0]  irq_sel;

    int total = 0;
    int bad = 0;
    logic [31:0] cap;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_holdoff_ctrl #(.SHORT_CYC(SC), .LONG_CYC(LC), .CHIP_VER(5'h03), .BOARD_ID(12'h1A7)) u_irq_holdoff_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse), .irq(irq),
        .sw_rst(sw_rst), .rx_on(rx_on), .tx_on(tx_on), .dma_on(dma_on), .tx_lock(tx_lock),
        .irq_sel(irq_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic rd, input logic [2:0] a,
                        input logic [31:0] d, input logic [16:0] e);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; evt_pulse = e;
        #1 cap = bus_rdata;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0; evt_pulse = '0;
    endtask

    function automatic logic [16:0] next_status(input logic [16:0] st, input logic [16:0] e, input bit ack);
        return (ack ? 17'd0 : st) | e;
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [16:0] m_st, m_en;
        logic        m_pend;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        step(0, 1, 3'd1, 0, 0); check("R1 peek", cap, 0);
        step(0, 1, 3'd2, 0, 0); check("R1 ack", cap, 0);
        step(0, 1, 3'd3, 0, 0); check("R1 mask", cap, 0);
        step(0, 1, 3'd4, 0, 0); check("R1 ctrl", cap, 0);
        check("R1 outputs", {26'd0, rx_on, tx_on, dma_on, tx_lock, irq_sel}, 0);

        // R8 identifier
        step(0, 1, 3'd0, 0, 0); check("R8 id", cap, {5'h03, 15'd0, 12'h1A7});

        // R2 / R3 latch and peek
        step(0, 0, 0, 0, 17'h00008);
        step(0, 1, 3'd1, 0, 0); check("R2 latch", cap, 32'h8);
        step(0, 1, 3'd1, 0, 0); check("R3 peek keeps", cap, 32'h8);

        // R4 acknowledge clears
        step(0, 1, 3'd2, 0, 0); check("R4 ack value", cap, 32'h8);
        step(0, 1, 3'd1, 0, 0); check("R4 cleared", cap, 0);

        // R4 same-cycle event wins
        step(0, 0, 0, 0, 17'h00020);
        step(0, 1, 3'd2, 0, 17'h00020); check("R4 ack value2", cap, 32'h20);
        step(0, 1, 3'd1, 0, 0); check("R4 event wins", cap, 32'h20);

        // R5 mask and registered irq
        step(1, 0, 3'd3, 32'h20, 0);
        check("R5 irq lag", {31'd0, irq}, 0);
        step(0, 0, 0, 0, 0);
        check("R5 irq up", {31'd0, irq}, 1);
        step(0, 1, 3'd3, 0, 0); check("R5 mask rb", cap, 32'h20);

        // R6 short holdoff
        step(1, 0, 3'd4, 32'h1, 0);
        check("R6 short masks", {31'd0, irq}, 0);
        step(0, 1, 3'd4, 0, 0); check("R6 short flag", cap, 32'h1);
        step(0, 0, 0, 0, 17'h00001);
        repeat (SC - 3) step(0, 0, 0, 0, 0);
        check("R6 short end-1", {31'd0, irq}, 0);
        step(0, 0, 0, 0, 0);
        check("R6 short expired", {31'd0, irq}, 1);
        step(0, 1, 3'd4, 0, 0); check("R6 short selfclr", cap, 0);
        step(0, 1, 3'd1, 0, 0); check("R6 latched during hold", cap, 32'h21);

        // R6 long holdoff, long wins
        step(1, 0, 3'd4, 32'h3, 0);
        step(0, 1, 3'd4, 0, 0); check("R6 long flag", cap, 32'h2);
        repeat (LC - 2) step(0, 0, 0, 0, 0);
        check("R6 long end-1", {31'd0, irq}, 0);
        step(0, 0, 0, 0, 0);
        check("R6 long expired", {31'd0, irq}, 1);

        // R7 control fields
        step(1, 0, 3'd4, 32'h1AC, 0);
        check("R7 outputs", {26'd0, irq_sel, tx_lock, dma_on, tx_on, rx_on}, {26'd0, 3'b110, 1'b1, 1'b0, 1'b1, 1'b1});
        step(0, 1, 3'd4, 0, 0); check("R7 readback", cap, 32'h1AC);

        // R9 unused offsets
        step(0, 1, 3'd5, 0, 0); check("R9 read", cap, 0);
        step(1, 0, 3'd6, 32'hFFFF_FFFF, 0);
        step(0, 1, 3'd1, 0, 0); check("R9 status kept", cap, 32'h21);
        step(0, 1, 3'd3, 0, 0); check("R9 mask kept", cap, 32'h20);
        step(0, 1, 3'd4, 0, 0); check("R9 ctrl kept", cap, 32'h1AC);

        // R8 soft reset
        step(1, 0, 3'd0, 32'h0, 0);
        check("R8 sw_rst pulse", {31'd0, sw_rst}, 1);
        check("R8 irq cleared", {31'd0, irq}, 0);
        step(0, 1, 3'd1, 0, 0); check("R8 status cleared", cap, 0);
        check("R8 sw_rst single", {31'd0, sw_rst}, 0);
        step(0, 1, 3'd3, 0, 0); check("R8 mask cleared", cap, 0);
        step(0, 1, 3'd4, 0, 0); check("R8 ctrl cleared", cap, 0);

        // random mix against model: R2 R3 R4 R5
        m_st = '0; m_en = '0; m_pend = 1'b0;
        for (int i = 0; i < 400; i++) begin
            logic [16:0] e;
            logic [31:0] d;
            int op;
            e  = 17'($urandom & $urandom & $urandom);
            op = int'($urandom % 4);
            d  = $urandom;
            case (op)
                1: step(0, 1, 3'd1, 0, e);
                2: step(0, 1, 3'd2, 0, e);
                3: step(1, 0, 3'd3, d, e);
                default: step(0, 0, 0, 0, e);
            endcase
            if (op == 1) check("R3 random peek", cap, {15'd0, m_st});
            if (op == 2) check("R4 random ack", cap, {15'd0, m_st});
            m_pend = |(m_st & m_en);
            m_st   = next_status(m_st, e, op == 2);
            if (op == 3) m_en = d[16:0];
            check("R5 random irq", {31'd0, irq}, {31'd0, m_pend});
        end
        step(0, 1, 3'd1, 0, 0); check("R2 random final", cap, {15'd0, m_st});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule